// File: doc/BRIEF.md
# Thermal Window Event Controller

This block watches a stream of signed temperature samples and compares each one with three programmable limits: an upper alarm bound, a lower alarm bound and a critical limit. It keeps three trip flags with selectable hysteresis, and from those flags it produces one event output meant to control an open-drain pin. The event can behave as a level (comparator) or as a latched notice of alarm-window crossings (interrupt) that software acknowledges. A bus front end writes the limit and control registers through strobes and reads them back from parallel outputs. An analog converter delivers the samples.

Temperatures are 13-bit two's complement values at 1/16 °C per LSB. Limits use the same alignment with a 0.25 °C step, so a limit word read as a 13-bit signed number is in the same 1/16 °C units as a sample. The control register holds two sticky lock bits. Once set, they protect the limits and the event-control fields until the next power-on reset. A shutdown bit stops sampling and silences the event.

Top module: `thermal_event_ctrl`

## Requirements
- R1: A limit write stores only bits 12:2 of `wr_data`. Bits 15:13 and 1:0 of `hi_rd`, `lo_rd` and `crit_rd` always read 0. All registers reset to 0.
- R2: Critical flag (`temp_word[15]`) sets on an accepted sample at or above the critical limit. It clears on a sample strictly below (critical − hysteresis) and holds in between.
- R3: Above flag (`temp_word[14]`) sets on a sample strictly above the upper bound. It clears on a sample at or below (upper − hysteresis) and holds in between.
- R4: Below flag (`temp_word[13]`) sets on a sample strictly below (lower − hysteresis). It clears on a sample at or above the lower bound and holds in between. `temp_word[12:0]` is the last accepted sample.
- R5: Hysteresis code in control bits 10:9 is 00, 01, 10 or 11. These codes give 0, 24, 48 or 96 units of 1/16 °C.
- R6: With control bit 0 = 0 (comparator), the event is asserted exactly while a trip condition holds. Writing control bit 5 (clear) has no effect in this mode.
- R7: With control bit 0 = 1 (interrupt), the event asserts after an accepted sample changes the above/below flags. A control write with bit 5 = 1 deasserts it until the next such change.
- R8: While the critical flag is set, the event follows the comparator rule whatever the mode, and clear writes are ignored.
- R9: With control bit 2 = 1 (critical only), only the critical flag can raise the event.
- R10: `evt_drive_low` is 0 when control bit 3 (enable) is 0. Otherwise it equals the asserted state when bit 1 = 0 (active low) and its inverse when bit 1 = 1 (active high).
- R11: Writing 1 to control bit 6 locks the upper and lower bounds; writing 1 to bit 7 locks the critical limit. Writes to a locked limit are dropped, and the lock bits clear only on reset.
- R12: While either lock is set, control bits 3:0 keep their value and bit 8 (shutdown) cannot be set. Bit 8 can always be cleared.
- R13: While bit 8 is 1, samples are ignored (flags and `temp_word` hold) and the event is deasserted.
- R14: `cfg_rd[4]` reads 1 exactly while the event is asserted and enabled; `cfg_rd[5]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| smp_vld | input | 1 | New temperature sample strobe |
| smp_temp | input | 13 | Sample, two's complement, 1/16 °C |
| wr_cfg | input | 1 | Control register write strobe |
| wr_hi | input | 1 | Upper bound write strobe |
| wr_lo | input | 1 | Lower bound write strobe |
| wr_crit | input | 1 | Critical limit write strobe |
| wr_data | input | 16 | Write data for all strobes |
| evt_drive_low | output | 1 | 1 = pull the event pin low |
| cfg_rd | output | 16 | Control register readback with status |
| hi_rd | output | 16 | Upper bound readback |
| lo_rd | output | 16 | Lower bound readback |
| crit_rd | output | 16 | Critical limit readback |
| temp_word | output | 16 | {critical, above, below, last sample} |

## Verification
The trip comparators get samples one unit on either side of each limit. This separates strict from inclusive comparisons for every flag. Samples that fall inside the hysteresis band, at its edge and just past it, are tried under each non-zero hysteresis code. These show whether a flag holds, clears and uses the right width. Event tests pair comparator and interrupt modes with repeated samples on the same side of a limit, window re-entry and critical excursions. These tell a level output from a crossing latch, and show whether clear is honoured or ignored. Lock and shutdown tests write both allowed and forbidden values, and read the outcome back through the register outputs.

// File: rtl/thermal_pkg.sv
// Package: shared widths, control field layout and hysteresis decoding
// for the thermal window event controller.
package thermal_pkg;

    localparam int TEMP_W    = 13;   // sample / limit width, two's complement
    localparam int REG_W     = 16;   // readback word width
    localparam int LIM_LSB   = 2;    // lowest stored limit bit
    localparam int HYST_STEP = 24;   // smallest non-zero hysteresis, 1/16 C
    localparam int HYST_W    = 8;    // width of decoded hysteresis

    // control word bit positions (software visible layout)
    localparam int C_MODE  = 0;
    localparam int C_POL   = 1;
    localparam int C_CONLY = 2;
    localparam int C_EN    = 3;
    localparam int C_STAT  = 4;
    localparam int C_CLR   = 5;
    localparam int C_ALK   = 6;
    localparam int C_CLK   = 7;
    localparam int C_SD    = 8;
    localparam int C_HYS0  = 9;

    typedef struct packed {
        logic [1:0] hyst;
        logic       sd;
        logic       crit_lk;
        logic       alarm_lk;
        logic       out_en;
        logic       crit_only;
        logic       pol_high;
        logic       irq_mode;
    } ctrl_t;

    // decode a hysteresis select code into 1/16 C units
    function automatic logic [HYST_W-1:0] hyst_units(input logic [1:0] code);
        logic [HYST_W-1:0] r;
        case (code)
            2'd0:    r = '0;
            2'd1:    r = HYST_W'(HYST_STEP);
            2'd2:    r = HYST_W'(HYST_STEP * 2);
            default: r = HYST_W'(HYST_STEP * 4);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thermal_limit_reg.sv
// Module: one programmable temperature limit.
// Stores bits TW-1:LSB of the write data and drops writes while locked.
// Assumes the caller has already decoded which limit a strobe targets.
module thermal_limit_reg #(
    parameter int TW  = 13,
    parameter int RW  = 16,
    parameter int LSB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          locked,
    input  logic [RW-1:0] wr_data,
    output logic [RW-1:0] value
);

    localparam int KEEP_W = TW - LSB;

    logic [KEEP_W-1:0] keep_q;

    // capture the kept bits on an unlocked write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keep_q <= '0;
        end else if (wr_en && !locked) begin
            keep_q <= wr_data[TW-1:LSB];
        end
    end

    assign value = {{(RW-TW){1'b0}}, keep_q, {LSB{1'b0}}};

endmodule

// File: rtl/thermal_ctrl_reg.sv
// Module: control register with sticky locks.
// Lock state before a write decides what that write may change. Clear-event
// is a pulse only and is never stored.
module thermal_ctrl_reg
    import thermal_pkg::*;
#(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [RW-1:0] wr_data,
    output ctrl_t         ctrl,
    output logic          clr_pulse
);

    ctrl_t ctrl_q;
    logic  locked;

    assign locked = ctrl_q.alarm_lk | ctrl_q.crit_lk;

    // update control fields under the lock rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.alarm_lk <= ctrl_q.alarm_lk | wr_data[C_ALK];
            ctrl_q.crit_lk  <= ctrl_q.crit_lk  | wr_data[C_CLK];
            ctrl_q.hyst     <= wr_data[C_HYS0+1:C_HYS0];
            if (!locked) begin
                ctrl_q.irq_mode  <= wr_data[C_MODE];
                ctrl_q.pol_high  <= wr_data[C_POL];
                ctrl_q.crit_only <= wr_data[C_CONLY];
                ctrl_q.out_en    <= wr_data[C_EN];
            end
            if (!wr_data[C_SD]) begin
                ctrl_q.sd <= 1'b0;
            end else if (!locked) begin
                ctrl_q.sd <= 1'b1;
            end
        end
    end

    assign ctrl      = ctrl_q;
    assign clr_pulse = wr_en & wr_data[C_CLR];

endmodule

// File: rtl/thermal_trip_detect.sv
// Module: three trip flags with hysteresis.
// Limits share the sample's 1/16 C alignment, so both are sign-extended
// and compared directly. The module flags a window crossing one cycle after
// the accepting sample, together with the new flag values.
module thermal_trip_detect
    import thermal_pkg::*;
#(
    parameter int TW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [TW-1:0] smp,
    input  logic [TW-1:0] lim_hi,
    input  logic [TW-1:0] lim_lo,
    input  logic [TW-1:0] lim_crit,
    input  logic [1:0]    hyst_sel,
    output logic          crit_st,
    output logic          above_st,
    output logic          below_st,
    output logic          win_cross,
    output logic [TW-1:0] smp_q
);

    localparam int CW = TW + 2;

    logic signed [CW-1:0] t_s, hi_s, lo_s, cr_s, h_s;
    logic                 crit_n, above_n, below_n;
    logic                 crit_q, above_q, below_q, cross_q;
    logic [TW-1:0]        smp_r;

    assign t_s  = {{(CW-TW){smp[TW-1]}}, smp};
    assign hi_s = {{(CW-TW){lim_hi[TW-1]}}, lim_hi};
    assign lo_s = {{(CW-TW){lim_lo[TW-1]}}, lim_lo};
    assign cr_s = {{(CW-TW){lim_crit[TW-1]}}, lim_crit};
    assign h_s  = {{(CW-HYST_W){1'b0}}, hyst_units(hyst_sel)};

    // next flag values: set rule first, then clear rule, else hold
    always_comb begin
        if (t_s >= cr_s)             crit_n = 1'b1;
        else if (t_s < cr_s - h_s)   crit_n = 1'b0;
        else                         crit_n = crit_q;

        if (t_s > hi_s)              above_n = 1'b1;
        else if (t_s <= hi_s - h_s)  above_n = 1'b0;
        else                         above_n = above_q;

        if (t_s < lo_s - h_s)        below_n = 1'b1;
        else if (t_s >= lo_s)        below_n = 1'b0;
        else                         below_n = below_q;
    end

    // register flags, sample and the crossing pulse on accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crit_q  <= 1'b0;
            above_q <= 1'b0;
            below_q <= 1'b0;
            cross_q <= 1'b0;
            smp_r   <= '0;
        end else if (accept) begin
            crit_q  <= crit_n;
            above_q <= above_n;
            below_q <= below_n;
            cross_q <= (above_n != above_q) || (below_n != below_q);
            smp_r   <= smp;
        end else begin
            cross_q <= 1'b0;
        end
    end

    assign crit_st   = crit_q;
    assign above_st  = above_q;
    assign below_st  = below_q;
    assign win_cross = cross_q;
    assign smp_q     = smp_r;

endmodule

// File: rtl/thermal_event_gen.sv
// Module: event state and pin drive.
// Comparator rule applies in comparator mode or while critical. The interrupt
// latch is used otherwise. Shutdown forces the event off and empties the latch.
module thermal_event_gen
    import thermal_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  clr_pulse,
    input  logic  crit_st,
    input  logic  above_st,
    input  logic  below_st,
    input  logic  win_cross,
    output logic  asserted,
    output logic  drive_low
);

    logic irq_q;
    logic level_cond;
    logic cmp_rule;

    assign level_cond = crit_st | (~ctrl.crit_only & (above_st | below_st));
    assign cmp_rule   = ~ctrl.irq_mode | crit_st;

    // interrupt latch: set on a window crossing, cleared by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (ctrl.sd || !ctrl.irq_mode) begin
            irq_q <= 1'b0;
        end else if (win_cross && !ctrl.crit_only) begin
            irq_q <= 1'b1;
        end else if (clr_pulse && !crit_st) begin
            irq_q <= 1'b0;
        end
    end

    assign asserted  = ~ctrl.sd & (cmp_rule ? level_cond : irq_q);
    assign drive_low = ctrl.out_en & (ctrl.pol_high ? ~asserted : asserted);

endmodule

// File: rtl/thermal_event_ctrl.sv
// Module: top of the thermal window event controller.
// Connects the three limit registers, the control register, the trip
// detector and the event generator, and forms the readback words.
// Assumes one write strobe per cycle and synchronous inputs.
module thermal_event_ctrl
    import thermal_pkg::*;
#(
    parameter int TW  = TEMP_W,
    parameter int RW  = REG_W,
    parameter int LSB = LIM_LSB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_vld,
    input  logic [TW-1:0] smp_temp,
    input  logic          wr_cfg,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic          wr_crit,
    input  logic [RW-1:0] wr_data,
    output logic          evt_drive_low,
    output logic [RW-1:0] cfg_rd,
    output logic [RW-1:0] hi_rd,
    output logic [RW-1:0] lo_rd,
    output logic [RW-1:0] crit_rd,
    output logic [RW-1:0] temp_word
);

    localparam int NLIM = 3;   // 0 upper, 1 lower, 2 critical

    ctrl_t         ctrl;
    logic          clr_pulse;
    logic [NLIM-1:0] lim_wr, lim_lock;
    logic [RW-1:0] lim_val [NLIM];
    logic          crit_st, above_st, below_st, win_cross;
    logic [TW-1:0] smp_q;
    logic          asserted;

    assign lim_wr   = {wr_crit, wr_lo, wr_hi};
    assign lim_lock = {ctrl.crit_lk, ctrl.alarm_lk, ctrl.alarm_lk};

    // one limit register per threshold
    generate
        for (genvar gi = 0; gi < NLIM; gi++) begin : g_lim
            thermal_limit_reg #(.TW(TW), .RW(RW), .LSB(LSB)) u_lim (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (lim_wr[gi]),
                .locked  (lim_lock[gi]),
                .wr_data (wr_data),
                .value   (lim_val[gi])
            );
        end
    endgenerate

    thermal_ctrl_reg #(.RW(RW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_cfg),
        .wr_data   (wr_data),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse)
    );

    thermal_trip_detect #(.TW(TW)) u_trip (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (smp_vld & ~ctrl.sd),
        .smp       (smp_temp),
        .lim_hi    (lim_val[0][TW-1:0]),
        .lim_lo    (lim_val[1][TW-1:0]),
        .lim_crit  (lim_val[2][TW-1:0]),
        .hyst_sel  (ctrl.hyst),
        .crit_st   (crit_st),
        .above_st  (above_st),
        .below_st  (below_st),
        .win_cross (win_cross),
        .smp_q     (smp_q)
    );

    thermal_event_gen u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .clr_pulse (clr_pulse),
        .crit_st   (crit_st),
        .above_st  (above_st),
        .below_st  (below_st),
        .win_cross (win_cross),
        .asserted  (asserted),
        .drive_low (evt_drive_low)
    );

    // readback word assembly
    always_comb begin
        cfg_rd                    = '0;
        cfg_rd[C_MODE]            = ctrl.irq_mode;
        cfg_rd[C_POL]             = ctrl.pol_high;
        cfg_rd[C_CONLY]           = ctrl.crit_only;
        cfg_rd[C_EN]              = ctrl.out_en;
        cfg_rd[C_STAT]            = asserted & ctrl.out_en;
        cfg_rd[C_ALK]             = ctrl.alarm_lk;
        cfg_rd[C_CLK]             = ctrl.crit_lk;
        cfg_rd[C_SD]              = ctrl.sd;
        cfg_rd[C_HYS0+1:C_HYS0]   = ctrl.hyst;
    end

    assign hi_rd     = lim_val[0];
    assign lo_rd     = lim_val[1];
    assign crit_rd   = lim_val[2];
    assign temp_word = {crit_st, above_st, below_st, smp_q};

endmodule

// File: rtl/thermal_event_ctrl_chk.sv
// Module: assertion checker for thermal_event_ctrl, attached by bind.
// Observes only the top-level ports.
module thermal_event_ctrl_chk #(
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          evt_drive_low,
    input logic [RW-1:0] cfg_rd,
    input logic [RW-1:0] hi_rd,
    input logic [RW-1:0] lo_rd,
    input logic [RW-1:0] crit_rd,
    input logic [RW-1:0] temp_word
);

    localparam logic [RW-1:0] LIM_MASK = RW'(16'h1FFC);

    a_r1_limit_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_rd | lo_rd | crit_rd) & ~LIM_MASK) == '0);

    a_r8_crit_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_word[15] && cfg_rd[3] && !cfg_rd[8]) |-> cfg_rd[4]);

    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd[3] |-> !evt_drive_low);

    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd[6] |=> cfg_rd[6]) and (cfg_rd[7] |=> cfg_rd[7]));

    a_r11_alarm_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[6] |=> ($stable(hi_rd) && $stable(lo_rd)));

    a_r11_crit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[7] |=> $stable(crit_rd));

    a_r12_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd[6] || cfg_rd[7]) |=> $stable(cfg_rd[3:0]));

    a_r12_no_sd_set: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_rd[6] || cfg_rd[7]) && !cfg_rd[8]) |=> !cfg_rd[8]);

    a_r13_sd_silent: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[8] |-> !cfg_rd[4]);

    a_r13_sd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[8] |=> $stable(temp_word));

    a_r14_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd[5]);

endmodule

bind thermal_event_ctrl thermal_event_ctrl_chk #(.RW(RW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_drive_low (evt_drive_low),
    .cfg_rd        (cfg_rd),
    .hi_rd         (hi_rd),
    .lo_rd         (lo_rd),
    .crit_rd       (crit_rd),
    .temp_word     (temp_word)
);

// File: tb/thermal_event_ctrl_tb_top.sv
// Directed bench for thermal_event_ctrl: one task per scenario.
module thermal_event_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_vld = 1'b0;
    logic [12:0] smp_temp = '0;
    logic        wr_cfg = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0, wr_crit = 1'b0;
    logic [15:0] wr_data = '0;
    logic        evt_drive_low;
    logic [15:0] cfg_rd, hi_rd, lo_rd, crit_rd, temp_word;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    thermal_event_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_temp(smp_temp),
        .wr_cfg(wr_cfg), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_crit(wr_crit),
        .wr_data(wr_data), .evt_drive_low(evt_drive_low), .cfg_rd(cfg_rd),
        .hi_rd(hi_rd), .lo_rd(lo_rd), .crit_rd(crit_rd), .temp_word(temp_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // sel: 0 cfg, 1 upper, 2 lower, 3 critical
    task automatic wr(input int sel, input logic [15:0] d);
        @(negedge clk);
        wr_data = d;
        wr_cfg = (sel == 0); wr_hi = (sel == 1); wr_lo = (sel == 2); wr_crit = (sel == 3);
        @(negedge clk);
        {wr_cfg, wr_hi, wr_lo, wr_crit} = '0;
    endtask

    task automatic smp(input int v);
        @(negedge clk);
        smp_vld = 1'b1; smp_temp = 13'(v);
        @(negedge clk);
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // standard limits: upper 80 C, lower 20 C, critical 100 C
    task automatic set_limits();
        wr(1, 16'd1280); wr(2, 16'd320); wr(3, 16'd1600);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 reset cfg", cfg_rd, 16'h0000);
        chk("R1 reset hi", hi_rd, 16'h0000);
        chk("R1 reset crit", crit_rd, 16'h0000);
        chk("R1 reset temp", temp_word, 16'h0000);
        chk("R10 reset drive", {15'd0, evt_drive_low}, 16'd0);
    endtask

    task automatic t_limits();
        wr(1, 16'hFFFF);
        chk("R1 hi mask", hi_rd, 16'h1FFC);
        wr(2, 16'h1F63);
        chk("R1 lo mask", lo_rd, 16'h1F60);
        wr(3, 16'h0643);
        chk("R1 crit mask", crit_rd, 16'h0640);
    endtask

    task automatic t_comparator();
        do_reset(); set_limits();
        wr(0, 16'h0008);
        smp(800);
        chk("R6 in window", temp_word, 16'h0320);
        chk("R6 no event", {15'd0, evt_drive_low}, 16'd0);
        smp(1281);
        chk("R3 above set", {13'd0, temp_word[15:13]}, 16'd2);
        chk("R6 event on above", {15'd0, evt_drive_low}, 16'd1);
        smp(1280);
        chk("R3 above clear at bound", {13'd0, temp_word[15:13]}, 16'd0);
        chk("R6 event follows", {15'd0, evt_drive_low}, 16'd0);
        smp(319);
        chk("R4 below set", {13'd0, temp_word[15:13]}, 16'd1);
        smp(320);
        chk("R4 below clear", {13'd0, temp_word[15:13]}, 16'd0);
        smp(1600);
        chk("R2 crit set at limit", {13'd0, temp_word[15:13]}, 16'd6);
        wr(0, 16'h0028);
        chk("R6 clear ignored", {15'd0, evt_drive_low}, 16'd1);
        smp(1599);
        chk("R2 crit clear", {13'd0, temp_word[15:13]}, 16'd2);
    endtask

    task automatic t_hyst();
        do_reset(); set_limits();
        wr(0, 16'h0400);
        smp(1281); smp(1240);
        chk("R5 above holds in band 48", {13'd0, temp_word[15:13]}, 16'd2);
        smp(1232);
        chk("R5 above clears at edge", {13'd0, temp_word[15:13]}, 16'd0);
        wr(0, 16'h0600);
        smp(1600); smp(1505);
        chk("R2 crit holds in band 96", temp_word[15] ? 16'd1 : 16'd0, 16'd1);
        smp(1503);
        chk("R2 crit clears below band", temp_word[15] ? 16'd1 : 16'd0, 16'd0);
        wr(0, 16'h0200);
        smp(300);
        chk("R4 no set above band 24", {13'd0, temp_word[15:13]}, 16'd0);
        smp(295);
        chk("R4 set below band", {13'd0, temp_word[15:13]}, 16'd1);
        smp(310);
        chk("R4 hold inside", {13'd0, temp_word[15:13]}, 16'd1);
        smp(320);
        chk("R4 clear at bound", {13'd0, temp_word[15:13]}, 16'd0);
    endtask

    task automatic t_interrupt();
        do_reset(); set_limits();
        wr(0, 16'h0009);
        smp(800);
        chk("R7 no crossing", {15'd0, evt_drive_low}, 16'd0);
        smp(1300);
        chk("R7 assert on crossing", {15'd0, evt_drive_low}, 16'd1);
        chk("R14 status bit", cfg_rd, 16'h0019);
        smp(1310);
        chk("R7 stays latched", {15'd0, evt_drive_low}, 16'd1);
        wr(0, 16'h0029);
        chk("R7 clear deasserts", {15'd0, evt_drive_low}, 16'd0);
        chk("R14 clear reads 0", {15'd0, cfg_rd[5]}, 16'd0);
        smp(1310);
        chk("R7 quiet without crossing", {15'd0, evt_drive_low}, 16'd0);
        smp(1200);
        chk("R7 leave re-asserts", {15'd0, evt_drive_low}, 16'd1);
        wr(0, 16'h0029);
        smp(1700);
        chk("R8 crit asserts", {15'd0, evt_drive_low}, 16'd1);
        wr(0, 16'h0029);
        chk("R8 clear ignored", {15'd0, evt_drive_low}, 16'd1);
        smp(1300);
        chk("R8 latch kept after crit", {15'd0, evt_drive_low}, 16'd1);
        wr(0, 16'h0029);
        chk("R7 clear after crit", {15'd0, evt_drive_low}, 16'd0);
    endtask

    task automatic t_critonly();
        do_reset(); set_limits();
        wr(0, 16'h000C);
        smp(1300);
        chk("R9 alarm no event", {15'd0, evt_drive_low}, 16'd0);
        smp(1650);
        chk("R9 crit event", {15'd0, evt_drive_low}, 16'd1);
        wr(0, 16'h000D);
        smp(100);
        smp(1300);
        chk("R9 irq crossing ignored", {15'd0, evt_drive_low}, 16'd0);
    endtask

    task automatic t_polarity();
        do_reset(); set_limits();
        wr(0, 16'h000A);
        smp(800);
        chk("R10 high idle pulls", {15'd0, evt_drive_low}, 16'd1);
        smp(1300);
        chk("R10 high asserted releases", {15'd0, evt_drive_low}, 16'd0);
        wr(0, 16'h0002);
        smp(800);
        chk("R10 disabled releases", {15'd0, evt_drive_low}, 16'd0);
    endtask

    task automatic t_shutdown();
        do_reset(); set_limits();
        wr(0, 16'h0108);
        smp(1300);
        chk("R13 sample ignored", temp_word, 16'h0000);
        chk("R13 no event", {15'd0, evt_drive_low}, 16'd0);
        wr(0, 16'h0008);
        smp(1300);
        chk("R13 resume", {13'd0, temp_word[15:13]}, 16'd2);
        wr(0, 16'h0108);
        chk("R13 event dropped", {15'd0, evt_drive_low}, 16'd0);
        chk("R14 status off in sd", {15'd0, cfg_rd[4]}, 16'd0);
    endtask

    task automatic t_locks();
        do_reset(); set_limits();
        wr(0, 16'h0048);
        wr(1, 16'd2000);
        chk("R11 hi locked", hi_rd, 16'd1280);
        wr(2, 16'd100);
        chk("R11 lo locked", lo_rd, 16'd320);
        wr(3, 16'd1700);
        chk("R11 crit open", crit_rd, 16'd1700);
        wr(0, 16'h0001);
        chk("R12 ctrl frozen, lock sticky", cfg_rd, 16'h0048);
        wr(0, 16'h0148);
        chk("R12 sd not settable", cfg_rd, 16'h0048);
        wr(0, 16'h00C8);
        wr(3, 16'd1800);
        chk("R11 crit locked", crit_rd, 16'd1700);
        do_reset();
        wr(0, 16'h0108);
        wr(0, 16'h0148);
        chk("R12 sd kept with lock", cfg_rd, 16'h0148);
        wr(0, 16'h0048);
        chk("R12 sd clear while locked", cfg_rd, 16'h0048);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_limits();
        t_comparator();
        t_hyst();
        t_interrupt();
        t_critonly();
        t_polarity();
        t_shutdown();
        t_locks();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule